// File: doc/BRIEF.md
# Read-First Multi-Port RAM

This block is a synchronous RAM with several write ports and several registered read ports, all on one clock. Every read port behaves read-first: when a read and a write hit the same word in the same cycle, the read returns the contents the word held before that write. A read of the same word in the following cycle returns the updated contents.

The storage core inside is write-transparent. Its registered reads already see writes that land on the same edge. Read-first behaviour comes from moving every write one cycle later. Each write port's address, data and per-bit enables go through a register stage before they reach the array. Each read port then merges any of those pending writes that match its address, using their bit enables.

Writes are enabled per bit, so partial writes touch only the selected bits. When several write ports hit one word in one cycle, the higher-numbered port takes the overlapping bits. Reset is synchronous and active-high. It clears the read data registers and the pending write enables, and it leaves the stored words as they are.

Top module: `rf_ram`

## Requirements
- R1: A read issued with read enable high in cycle t returns, on rd_data in cycle t+1, the word as it stood before any write presented in cycle t (read-first on collision).
- R2: A write presented in cycle t (not a reset cycle) is returned by any read of that address issued in cycle t+1 or later.
- R3: Write enables are per bit: bit b of wr_be for a port selects bit b of its wr_data. Bits with a zero enable keep their previous stored value, both in storage and in reads of the next cycle.
- R4: When several write ports write one address in one cycle, a higher port index overrides a lower one on bits both enable. Bits enabled by only one port take that port's data.
- R5: While a read port's enable is low, its rd_data keeps its previous value.
- R6: Reset (rst high at a clock edge) sets every rd_data to zero and discards writes presented in that cycle. Stored words are kept, including a write presented in the cycle just before reset.
- R7: Read ports are independent: two ports reading the same address in the same cycle return identical data, and ports reading different addresses each return their own word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all ports, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_addr | input | NUM_WR*ADDR_W | Write address per write port |
| wr_data | input | NUM_WR*DATA_W | Write data per write port |
| wr_be | input | NUM_WR*DATA_W | Per-bit write enable per write port |
| rd_en | input | NUM_RD | Read enable per read port |
| rd_addr | input | NUM_RD*ADDR_W | Read address per read port |
| rd_data | output | NUM_RD*DATA_W | Registered read data per read port |

## Verification
A read and a write can hit the same word in the same cycle. The delayed write of the previous cycle can also be pending on the word a read wants. Directed tasks set up both cases on purpose: same-cycle collisions, back-to-back writes to one word with a read on every cycle, and partial and overlapping multi-port writes. A random phase confines all addresses to four words so that collisions are frequent. Every read result is compared with a bench model. The model returns the contents as they stood before the current cycle's writes, and then applies those writes in port order bit by bit.

// File: rtl/rf_wr_delay.sv
module rf_wr_delay #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] be_i,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q,
  output logic [DATA_W-1:0] be_q
);
  // Address and data carry no reset: only the enables decide if a write lands.
  always_ff @(posedge clk) begin
    addr_q <= addr_i;
    data_q <= data_i;
    if (rst) be_q <= '0;
    else     be_q <= be_i;
  end
endmodule

// File: rtl/rf_rd_lane.sv
module rf_rd_lane #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int NUM_WR = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           en_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [DATA_W-1:0]              arr_word_i,
  input  logic [NUM_WR-1:0][ADDR_W-1:0]  pend_addr_i,
  input  logic [NUM_WR-1:0][DATA_W-1:0]  pend_data_i,
  input  logic [NUM_WR-1:0][DATA_W-1:0]  pend_be_i,
  output logic [DATA_W-1:0]              data_q
);
  logic [DATA_W-1:0] merged;

  // Pending writes land on this edge; fold them in port order so the
  // highest-numbered matching port owns any bit it enables.
  always_comb begin
    merged = arr_word_i;
    for (int p = 0; p < NUM_WR; p++) begin
      if (pend_addr_i[p] == addr_i)
        merged = (merged & ~pend_be_i[p]) | (pend_data_i[p] & pend_be_i[p]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       data_q <= '0;
    else if (en_i) data_q <= merged;
  end
endmodule

// File: rtl/rf_core.sv
module rf_core #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int NUM_WR = 2,
  parameter int NUM_RD = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_WR-1:0][ADDR_W-1:0]  pend_addr_i,
  input  logic [NUM_WR-1:0][DATA_W-1:0]  pend_data_i,
  input  logic [NUM_WR-1:0][DATA_W-1:0]  pend_be_i,
  input  logic [NUM_RD-1:0]              rd_en_i,
  input  logic [NUM_RD-1:0][ADDR_W-1:0]  rd_addr_i,
  output logic [NUM_RD-1:0][DATA_W-1:0]  rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Later ports in the loop win on shared bits (last nonblocking update).
  always_ff @(posedge clk) begin
    for (int p = 0; p < NUM_WR; p++) begin
      for (int b = 0; b < DATA_W; b++) begin
        if (pend_be_i[p][b]) mem[pend_addr_i[p]][b] <= pend_data_i[p][b];
      end
    end
  end

  for (genvar g = 0; g < NUM_RD; g++) begin : g_rd
    rf_rd_lane #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W),
      .NUM_WR(NUM_WR)
    ) u_lane (
      .clk         (clk),
      .rst         (rst),
      .en_i        (rd_en_i[g]),
      .addr_i      (rd_addr_i[g]),
      .arr_word_i  (mem[rd_addr_i[g]]),
      .pend_addr_i (pend_addr_i),
      .pend_data_i (pend_data_i),
      .pend_be_i   (pend_be_i),
      .data_q      (rd_data_o[g])
    );
  end
endmodule

// File: rtl/rf_ram.sv
module rf_ram #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int NUM_WR = 2,
  parameter int NUM_RD = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_WR-1:0][ADDR_W-1:0]  wr_addr,
  input  logic [NUM_WR-1:0][DATA_W-1:0]  wr_data,
  input  logic [NUM_WR-1:0][DATA_W-1:0]  wr_be,
  input  logic [NUM_RD-1:0]              rd_en,
  input  logic [NUM_RD-1:0][ADDR_W-1:0]  rd_addr,
  output logic [NUM_RD-1:0][DATA_W-1:0]  rd_data
);
  logic [NUM_WR-1:0][ADDR_W-1:0] pend_addr;
  logic [NUM_WR-1:0][DATA_W-1:0] pend_data;
  logic [NUM_WR-1:0][DATA_W-1:0] pend_be;

  for (genvar w = 0; w < NUM_WR; w++) begin : g_wr
    rf_wr_delay #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W)
    ) u_dly (
      .clk    (clk),
      .rst    (rst),
      .addr_i (wr_addr[w]),
      .data_i (wr_data[w]),
      .be_i   (wr_be[w]),
      .addr_q (pend_addr[w]),
      .data_q (pend_data[w]),
      .be_q   (pend_be[w])
    );
  end

  rf_core #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .NUM_WR(NUM_WR),
    .NUM_RD(NUM_RD)
  ) u_core (
    .clk         (clk),
    .rst         (rst),
    .pend_addr_i (pend_addr),
    .pend_data_i (pend_data),
    .pend_be_i   (pend_be),
    .rd_en_i     (rd_en),
    .rd_addr_i   (rd_addr),
    .rd_data_o   (rd_data)
  );
endmodule

// File: rtl/rf_ram_chk.sv
module rf_ram_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int NUM_WR = 2,
  parameter int NUM_RD = 2
) (
  input logic                           clk,
  input logic                           rst,
  input logic [NUM_WR-1:0][ADDR_W-1:0]  wr_addr,
  input logic [NUM_WR-1:0][DATA_W-1:0]  wr_data,
  input logic [NUM_WR-1:0][DATA_W-1:0]  wr_be,
  input logic [NUM_RD-1:0]              rd_en,
  input logic [NUM_RD-1:0][ADDR_W-1:0]  rd_addr,
  input logic [NUM_RD-1:0][DATA_W-1:0]  rd_data,
  input logic [NUM_WR-1:0][DATA_W-1:0]  pend_be
);
  localparam int TOP = NUM_WR - 1;

  // Counts edges since reset so $past never reaches before time zero.
  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (rst)               warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  // R6: reset clears read data and drops any pending write.
  a_r6_reset_clears: assert property (@(posedge clk)
    rst |=> (rd_data == '0) && (pend_be == '0));

  // R2: a full write on the top port is read back one cycle later.
  a_r2_next_cycle_visible: assert property (@(posedge clk) disable iff (rst)
    (warm != 2'd0 && !$past(rst) && $past(wr_be[TOP]) == '1 &&
     rd_en[0] && rd_addr[0] == $past(wr_addr[TOP]))
    |=> rd_data[0] == $past(wr_data[TOP], 2));

  for (genvar r = 0; r < NUM_RD; r++) begin : g_hold
    // R5: a disabled read port holds its output.
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
      !rd_en[r] |=> $stable(rd_data[r]));
  end

  if (NUM_RD > 1) begin : g_pair
    // R7: two ports on one address agree.
    a_r7_same_addr: assert property (@(posedge clk) disable iff (rst)
      (rd_en[0] && rd_en[1] && rd_addr[0] == rd_addr[1])
      |=> rd_data[0] == rd_data[1]);
  end
endmodule

bind rf_ram rf_ram_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .NUM_WR(NUM_WR),
  .NUM_RD(NUM_RD)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .wr_be   (wr_be),
  .rd_en   (rd_en),
  .rd_addr (rd_addr),
  .rd_data (rd_data),
  .pend_be (pend_be)
);

// File: tb/rf_ram_bench.sv
module rf_ram_bench;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int NUM_WR = 2;
  localparam int NUM_RD = 2;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst;
  logic [NUM_WR-1:0][ADDR_W-1:0] wr_addr;
  logic [NUM_WR-1:0][DATA_W-1:0] wr_data;
  logic [NUM_WR-1:0][DATA_W-1:0] wr_be;
  logic [NUM_RD-1:0]             rd_en;
  logic [NUM_RD-1:0][ADDR_W-1:0] rd_addr;
  logic [NUM_RD-1:0][DATA_W-1:0] rd_data;

  always #4 clk = ~clk;

  rf_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_WR(NUM_WR), .NUM_RD(NUM_RD))
  u_rf_ram (
    .clk(clk), .rst(rst), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  int n_tests = 0;
  int n_fail  = 0;
  logic [DATA_W-1:0] ref_mem [DEPTH];
  logic [DATA_W-1:0] exp_q   [NUM_RD];

  task automatic check(input string req, input int port,
                       input logic [DATA_W-1:0] got, input logic [DATA_W-1:0] want);
    n_tests++;
    if (got !== want) begin
      n_fail++;
      $display("FAIL %s rd port %0d: got %h expected %h", req, port, got, want);
    end
  endtask

  task automatic idle();
    wr_be = '0; wr_addr = '0; wr_data = '0; rd_en = '0; rd_addr = '0;
  endtask

  // One clock: model read-first at the edge, then apply writes in port order.
  task automatic step(input string req);
    @(posedge clk);
    for (int r = 0; r < NUM_RD; r++) begin
      if (rst)           exp_q[r] = '0;
      else if (rd_en[r]) exp_q[r] = ref_mem[rd_addr[r]];
    end
    if (!rst) begin
      for (int p = 0; p < NUM_WR; p++)
        for (int b = 0; b < DATA_W; b++)
          if (wr_be[p][b]) ref_mem[wr_addr[p]][b] = wr_data[p][b];
    end
    @(negedge clk);
    for (int r = 0; r < NUM_RD; r++) check(req, r, rd_data[r], exp_q[r]);
  endtask

  task automatic t_reset();
    rst = 1'b1; idle();
    step("R6"); step("R6");
    rst = 1'b0;
  endtask

  task automatic t_fill();
    for (int a = 0; a < DEPTH; a++) begin
      idle();
      wr_addr[0] = ADDR_W'(a); wr_data[0] = DATA_W'(a * 37 + 11); wr_be[0] = '1;
      step("R5");
    end
    idle();
    for (int a = 0; a < DEPTH; a++) begin
      rd_en = '1; rd_addr[0] = ADDR_W'(a); rd_addr[1] = ADDR_W'(DEPTH - 1 - a);
      step("R2");
    end
  endtask

  task automatic t_collide();
    idle();
    wr_addr[1] = 4'd3; wr_data[1] = 8'hC5; wr_be[1] = '1;
    rd_en = '1; rd_addr[0] = 4'd3; rd_addr[1] = 4'd3;
    step("R1");
    wr_be = '0;
    step("R2");
    step("R2");
  endtask

  task automatic t_back_to_back();
    idle();
    rd_en[0] = 1'b1; rd_addr[0] = 4'd7;
    for (int k = 0; k < 4; k++) begin
      wr_addr[0] = 4'd7; wr_data[0] = DATA_W'(8'h10 + k); wr_be[0] = '1;
      step("R1");
    end
    wr_be = '0;
    step("R2");
  endtask

  task automatic t_partial();
    idle();
    wr_addr[0] = 4'd5; wr_data[0] = 8'hAA; wr_be[0] = 8'h0F;
    step("R3");
    wr_be = '0; rd_en = '1; rd_addr[0] = 4'd5; rd_addr[1] = 4'd5;
    step("R3");
    wr_addr[1] = 4'd5; wr_data[1] = 8'h00; wr_be[1] = 8'b1001_0010;
    step("R3");
    wr_be = '0;
    step("R3");
  endtask

  task automatic t_priority();
    idle();
    wr_addr[0] = 4'd9; wr_data[0] = 8'hFF; wr_be[0] = 8'hF0;
    wr_addr[1] = 4'd9; wr_data[1] = 8'h00; wr_be[1] = 8'h3C;
    step("R4");
    wr_be = '0; rd_en[0] = 1'b1; rd_addr[0] = 4'd9;
    step("R4");
    wr_addr[0] = 4'd9; wr_data[0] = 8'h5A; wr_be[0] = '1;
    wr_addr[1] = 4'd9; wr_data[1] = 8'hA5; wr_be[1] = '1;
    step("R4");
    wr_be = '0;
    step("R4");
  endtask

  task automatic t_hold();
    idle();
    rd_en = '1; rd_addr[0] = 4'd2; rd_addr[1] = 4'd12;
    step("R5");
    rd_en = '0;
    wr_addr[0] = 4'd2; wr_data[0] = 8'h3E; wr_be[0] = '1;
    rd_addr[0] = 4'd4;
    step("R5");
    wr_be = '0;
    step("R5");
    rd_en = '1; rd_addr[0] = 4'd2;
    step("R5");
  endtask

  task automatic t_dual();
    idle();
    rd_en = '1; rd_addr[0] = 4'd11; rd_addr[1] = 4'd11;
    step("R7");
    rd_addr[1] = 4'd1;
    step("R7");
  endtask

  task automatic t_mid_reset();
    idle();
    wr_addr[0] = 4'd6; wr_data[0] = 8'h66; wr_be[0] = '1;
    step("R6");
    rst = 1'b1;
    wr_addr[0] = 4'd8; wr_data[0] = 8'h88; wr_be[0] = '1;
    step("R6");
    rst = 1'b0; idle();
    rd_en = '1; rd_addr[0] = 4'd6; rd_addr[1] = 4'd8;
    step("R6");
  endtask

  task automatic t_random();
    for (int k = 0; k < 300; k++) begin
      for (int p = 0; p < NUM_WR; p++) begin
        wr_addr[p] = ADDR_W'($urandom_range(0, 3));
        wr_data[p] = DATA_W'($urandom);
        wr_be[p]   = ($urandom_range(0, 3) == 0) ? '0 : DATA_W'($urandom);
      end
      for (int r = 0; r < NUM_RD; r++) begin
        rd_en[r]   = ($urandom_range(0, 4) != 0);
        rd_addr[r] = ADDR_W'($urandom_range(0, 3));
      end
      step("R1 R3 R4 R7");
    end
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1;
    idle();
    t_reset();
    t_fill();
    t_collide();
    t_back_to_back();
    t_partial();
    t_priority();
    t_hold();
    t_dual();
    t_mid_reset();
    t_random();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule